// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block is a numerically controlled oscillator. It produces the colour subcarrier phase for a composite video encoder that supports the NTSC, PAL and SECAM families. A 32-bit accumulator adds a frequency word on every accumulation-rate enable pulse and wraps modulo 2^32. A word of 0x80000000 equals the pixel rate, and the enable runs at twice the pixel rate. The top bits of the accumulator, after a programmable phase offset is added, leave the block and go to an external sine lookup.

The frequency word is either a built-in constant chosen by a 2-bit standard code or a word programmed through a small write port. In SECAM the block alternates between two centre frequencies, one per line: the programmed word (red difference) and a separately held blue-difference word. Each frame restarts on the red-difference word. Changes to the word take effect only on a line-start strobe, so a line never mixes two frequencies. The offset is applied outside the accumulator, so changing it moves the phase without changing the rate.

Top module: `subcarrier_nco`

## Requirements
- R1: After rst_ni is released, phase_o is 0 and every register holds its default: programmed word 0, offset 0, control 0, blue word 0x284BDA13, active word 0x21F07C1F.
- R2: On each cycle with tick_i high the accumulator adds the active word modulo 2^32. With no tick and no write, phase_o holds.
- R3: With custom and SECAM both clear, control bits [1:0] select a built-in word: 0 gives 0x21F07C1F, 1 gives 0x2A098ACB, 2 gives 0x21E6EFE3, 3 gives 0x21F69446.
- R4: With control bit 3 (custom) set and SECAM clear, the programmed word replaces the built-in word. Its upper half is written at address 0 and its lower half at address 1. A programmed word is ignored while custom is clear.
- R5: phase_o is bits [31:22] of (accumulator + offset·2^24). The offset is written at address 2, bits [7:0], so 256 steps make a full turn. An offset write takes effect in the next cycle and does not change the accumulated value.
- R6: With control bit 2 (SECAM) set, lines alternate between the programmed word, whatever the custom bit says, and the blue word. The blue word's upper half is at address 4 and its lower half at address 5.
- R7: A frame_start_i pulse makes the next line use the programmed word. When frame_start_i and line_start_i fall in the same cycle, that line uses the programmed word.
- R8: A word, standard or mode change reaches the accumulator only on a line_start_i cycle. A tick in that same cycle already adds the new word.
- R9: Writing data bit 0 = 1 at address 6 clears the accumulator and restores every register to its R1 default in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Write data |
| tick_i | input | 1 | Accumulation enable, twice the pixel rate |
| line_start_i | input | 1 | Line-start strobe |
| frame_start_i | input | 1 | Frame-start strobe |
| phase_o | output | 10 | Offset subcarrier phase for sine lookup |

## Verification
Two functions can fall in the same cycle. The line-start reload of the active word can coincide with an accumulation tick, and in SECAM the frame restart can coincide with the line alternation. The bench drives line_start_i together with tick_i and expects the accumulator to grow by the newly selected word, not the old one. It also drives frame_start_i together with line_start_i in SECAM and expects that line to run on the red-difference word and the next line on the blue-difference word. Both cases are judged by comparing phase_o against a bench model of accumulated words.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;
  localparam int unsigned ADR_FHI  = 0;
  localparam int unsigned ADR_FLO  = 1;
  localparam int unsigned ADR_OFS  = 2;
  localparam int unsigned ADR_CTRL = 3;
  localparam int unsigned ADR_DHI  = 4;
  localparam int unsigned ADR_DLO  = 5;
  localparam int unsigned ADR_RST  = 6;

  localparam logic [31:0] DB_DEFAULT = 32'h284B_DA13;

  typedef struct packed {
    logic       custom;
    logic       secam;
    logic [1:0] std_sel;
  } ctrl_t;

  function automatic logic [31:0] builtin_word(input logic [1:0] sel);
    case (sel)
      2'd0:    builtin_word = 32'h21F0_7C1F;
      2'd1:    builtin_word = 32'h2A09_8ACB;
      2'd2:    builtin_word = 32'h21E6_EFE3;
      default: builtin_word = 32'h21F6_9446;
    endcase
  endfunction
endpackage

// File: rtl/nco_regs.sv
`timescale 1ns/1ps
module nco_regs
  import nco_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned OFS_W  = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [HALF_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] prog_word_o,
  output logic [WORD_W-1:0] db_word_o,
  output logic [OFS_W-1:0]  ofs_o,
  output ctrl_t             ctrl_o,
  output logic              sreset_o
);
  localparam logic [WORD_W-1:0] DB_RST = WORD_W'(DB_DEFAULT);

  assign sreset_o = wr_en_i && (wr_addr_i == ADDR_W'(ADR_RST)) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_word_o <= '0;
      db_word_o   <= DB_RST;
      ofs_o       <= '0;
      ctrl_o      <= '0;
    end else if (sreset_o) begin
      prog_word_o <= '0;
      db_word_o   <= DB_RST;
      ofs_o       <= '0;
      ctrl_o      <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_W'(ADR_FHI):  prog_word_o[WORD_W-1:HALF_W] <= wr_data_i;
        ADDR_W'(ADR_FLO):  prog_word_o[HALF_W-1:0]      <= wr_data_i;
        ADDR_W'(ADR_OFS):  ofs_o  <= wr_data_i[OFS_W-1:0];
        ADDR_W'(ADR_CTRL): ctrl_o <= ctrl_t'(wr_data_i[$bits(ctrl_t)-1:0]);
        ADDR_W'(ADR_DHI):  db_word_o[WORD_W-1:HALF_W]   <= wr_data_i;
        ADDR_W'(ADR_DLO):  db_word_o[HALF_W-1:0]        <= wr_data_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nco_word_sel.sv
`timescale 1ns/1ps
module nco_word_sel
  import nco_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sreset_i,
  input  logic              line_start_i,
  input  logic              frame_start_i,
  input  ctrl_t             ctrl_i,
  input  logic [WORD_W-1:0] prog_word_i,
  input  logic [WORD_W-1:0] db_word_i,
  output logic [WORD_W-1:0] act_word_o,
  output logic [WORD_W-1:0] eff_word_o
);
  localparam logic [WORD_W-1:0] RST_WORD = WORD_W'(builtin_word(2'd0));

  logic              next_db_q;
  logic              use_db;
  logic [WORD_W-1:0] cand;

  // frame start in the same cycle forces the red-difference word
  assign use_db = next_db_q & ~frame_start_i;

  always_comb begin
    if (ctrl_i.secam)       cand = use_db ? db_word_i : prog_word_i;
    else if (ctrl_i.custom) cand = prog_word_i;
    else                    cand = WORD_W'(builtin_word(ctrl_i.std_sel));
  end

  assign eff_word_o = line_start_i ? cand : act_word_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_word_o <= RST_WORD;
      next_db_q  <= 1'b0;
    end else if (sreset_i) begin
      act_word_o <= RST_WORD;
      next_db_q  <= 1'b0;
    end else if (line_start_i) begin
      act_word_o <= cand;
      next_db_q  <= ctrl_i.secam & ~use_db;
    end else if (frame_start_i) begin
      next_db_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/nco_accum.sv
`timescale 1ns/1ps
module nco_accum #(
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned OFS_W   = 8,
  parameter int unsigned PHASE_W = 10,
  localparam int unsigned OFS_SH = ACC_W - OFS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sreset_i,
  input  logic               tick_i,
  input  logic [ACC_W-1:0]   step_i,
  input  logic [OFS_W-1:0]   ofs_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (sreset_i) acc_q <= '0;
    else if (tick_i)   acc_q <= acc_q + step_i;
  end

  assign sum     = acc_q + {ofs_i, {OFS_SH{1'b0}}};
  assign phase_o = sum[ACC_W-1 -: PHASE_W];
endmodule

// File: rtl/subcarrier_nco.sv
`timescale 1ns/1ps
module subcarrier_nco
  import nco_pkg::*;
#(
  parameter int unsigned HALF_W  = 16,
  parameter int unsigned OFS_W   = 8,
  parameter int unsigned PHASE_W = 10,
  parameter int unsigned ADDR_W  = 3,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [HALF_W-1:0]  wr_data_i,
  input  logic               tick_i,
  input  logic               line_start_i,
  input  logic               frame_start_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [WORD_W-1:0] prog_word_w;
  logic [WORD_W-1:0] db_word_w;
  logic [WORD_W-1:0] act_word_w;
  logic [WORD_W-1:0] eff_word_w;
  logic [OFS_W-1:0]  ofs_w;
  ctrl_t             ctrl_w;
  logic              sreset_w;

  nco_regs #(.HALF_W(HALF_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .prog_word_o(prog_word_w),
    .db_word_o  (db_word_w),
    .ofs_o      (ofs_w),
    .ctrl_o     (ctrl_w),
    .sreset_o   (sreset_w)
  );

  nco_word_sel #(.WORD_W(WORD_W)) u_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sreset_i     (sreset_w),
    .line_start_i (line_start_i),
    .frame_start_i(frame_start_i),
    .ctrl_i       (ctrl_w),
    .prog_word_i  (prog_word_w),
    .db_word_i    (db_word_w),
    .act_word_o   (act_word_w),
    .eff_word_o   (eff_word_w)
  );

  nco_accum #(.ACC_W(WORD_W), .OFS_W(OFS_W), .PHASE_W(PHASE_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sreset_i(sreset_w),
    .tick_i  (tick_i),
    .step_i  (eff_word_w),
    .ofs_i   (ofs_w),
    .phase_o (phase_o)
  );
endmodule

// File: rtl/subcarrier_nco_chk.sv
`timescale 1ns/1ps
module subcarrier_nco_chk
  import nco_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned PHASE_W = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               line_start_i,
  input logic               frame_start_i,
  input logic               wr_en_i,
  input logic               sreset_i,
  input ctrl_t              ctrl_i,
  input logic [WORD_W-1:0]  prog_word_i,
  input logic [WORD_W-1:0]  act_word_i,
  input logic [PHASE_W-1:0] phase_i
);
  assert_phase_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(phase_i));

  assert_builtin_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !wr_en_i && !ctrl_i.secam && !ctrl_i.custom)
    |=> act_word_i == WORD_W'(builtin_word($past(ctrl_i.std_sel))));

  assert_custom_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !wr_en_i && !ctrl_i.secam && ctrl_i.custom)
    |=> act_word_i == $past(prog_word_i));

  assert_frame_dr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && frame_start_i && !wr_en_i && ctrl_i.secam)
    |=> act_word_i == $past(prog_word_i));

  assert_line_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_start_i && !sreset_i) |=> $stable(act_word_i));
endmodule

bind subcarrier_nco subcarrier_nco_chk #(.WORD_W(WORD_W), .PHASE_W(PHASE_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .line_start_i (line_start_i),
  .frame_start_i(frame_start_i),
  .wr_en_i      (wr_en_i),
  .sreset_i     (sreset_w),
  .ctrl_i       (ctrl_w),
  .prog_word_i  (prog_word_w),
  .act_word_i   (act_word_w),
  .phase_i      (phase_o)
);

// File: tb/subcarrier_nco_tb_top.sv
`timescale 1ns/1ps
module subcarrier_nco_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        line = 1'b0;
  logic        frame = 1'b0;
  logic [9:0]  phase;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] m_acc;

  localparam logic [31:0] W_NTSC = 32'h21F0_7C1F;
  localparam logic [31:0] W_PAL  = 32'h2A09_8ACB;
  localparam logic [31:0] W_PALN = 32'h21F6_9446;
  localparam logic [31:0] W_DR   = 32'h29C7_1C72;
  localparam logic [31:0] W_DB   = 32'h284B_DA13;

  always #2.5 clk = ~clk;

  subcarrier_nco dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_i(tick), .line_start_i(line),
    .frame_start_i(frame), .phase_o(phase)
  );

  typedef struct packed {
    logic [1:0]  std_sel;
    logic        custom;
    logic [7:0]  ofs;
    logic [31:0] word;
    logic [15:0] ticks;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 8'h00, 32'h0000_0000, 16'd5},
    '{2'd1, 1'b0, 8'h28, 32'h0000_0000, 16'd7},
    '{2'd2, 1'b0, 8'h00, 32'h0000_0000, 16'd100},
    '{2'd3, 1'b0, 8'h80, 32'h0000_0000, 16'd33},
    '{2'd1, 1'b1, 8'h00, 32'h8000_0000, 16'd3},
    '{2'd0, 1'b1, 8'h00, 32'hFFFF_FFFF, 16'd4},
    '{2'd2, 1'b1, 8'hFF, 32'h1234_5678, 16'd1000},
    '{2'd0, 1'b0, 8'h00, 32'h1234_5678, 16'd10}
  };

  function automatic logic [31:0] std_word(input logic [1:0] s);
    case (s)
      2'd0: return 32'h21F0_7C1F;
      2'd1: return 32'h2A09_8ACB;
      2'd2: return 32'h21E6_EFE3;
      default: return 32'h21F6_9446;
    endcase
  endfunction

  function automatic logic [9:0] exp_phase(input logic [31:0] a, input logic [7:0] o);
    logic [31:0] s;
    s = a + {o, 24'h0};
    return s[31:22];
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: phase_o=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic l, input logic f, input logic t);
    @(negedge clk); line = l; frame = f; tick = t;
    @(negedge clk); line = 1'b0; frame = 1'b0; tick = 1'b0;
  endtask

  task automatic run(input int n, input logic [31:0] w);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    m_acc = m_acc + 32'(64'(w) * 64'(n));
  endtask

  task automatic sreset();
    wr(3'd6, 16'h0001);
    m_acc = '0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_acc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset phase", phase, 10'd0);
    run(2, W_NTSC);
    check("R1 reset active word", phase, exp_phase(m_acc, 8'h00));

    // R3 R4 R5 table walk
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      sreset();
      wr(3'd0, VECS[i].word[31:16]);
      wr(3'd1, VECS[i].word[15:0]);
      wr(3'd2, {8'h00, VECS[i].ofs});
      wr(3'd3, {12'h0, VECS[i].custom, 1'b0, VECS[i].std_sel});
      pulse(1'b1, 1'b0, 1'b0);
      w = VECS[i].custom ? VECS[i].word : std_word(VECS[i].std_sel);
      run(int'(VECS[i].ticks), w);
      check(VECS[i].custom ? "R4 custom word" : "R3 builtin word",
            phase, exp_phase(m_acc, VECS[i].ofs));
    end

    // R2 hold without tick
    sreset();
    wr(3'd3, 16'h0001);
    pulse(1'b1, 1'b0, 1'b0);
    run(3, W_PAL);
    repeat (5) @(negedge clk);
    check("R2 hold", phase, exp_phase(m_acc, 8'h00));

    // R5 offset moves phase, not rate
    wr(3'd2, 16'h0028);
    check("R5 offset applied", phase, exp_phase(m_acc, 8'h28));
    run(4, W_PAL);
    check("R5 rate kept", phase, exp_phase(m_acc, 8'h28));
    wr(3'd2, 16'h0000);
    check("R5 offset removed", phase, exp_phase(m_acc, 8'h00));

    // R8 change waits for line start; strobe cycle uses new word
    wr(3'd3, 16'h0003);
    run(5, W_PAL);
    check("R8 old word kept", phase, exp_phase(m_acc, 8'h00));
    pulse(1'b1, 1'b0, 1'b1);
    m_acc = m_acc + W_PALN;
    check("R8 new word on strobe tick", phase, exp_phase(m_acc, 8'h00));

    // R6 R7 SECAM alternation with default blue word
    sreset();
    wr(3'd0, W_DR[31:16]);
    wr(3'd1, W_DR[15:0]);
    wr(3'd3, 16'h0004);
    pulse(1'b1, 1'b1, 1'b0);
    run(10, W_DR);
    check("R7 frame+line gives Dr", phase, exp_phase(m_acc, 8'h00));
    pulse(1'b1, 1'b0, 1'b0);
    run(10, W_DB);
    check("R6 Db default line", phase, exp_phase(m_acc, 8'h00));
    pulse(1'b1, 1'b0, 1'b0);
    run(10, W_DR);
    check("R6 back to Dr", phase, exp_phase(m_acc, 8'h00));
    pulse(1'b1, 1'b0, 1'b0);
    run(2, W_DB);
    pulse(1'b0, 1'b1, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    run(3, W_DR);
    check("R7 frame alone restarts on Dr", phase, exp_phase(m_acc, 8'h00));
    wr(3'd3, 16'h000C);
    pulse(1'b1, 1'b1, 1'b0);
    run(2, W_DR);
    check("R6 Dr regardless of custom", phase, exp_phase(m_acc, 8'h00));
    wr(3'd4, 16'h0001);
    wr(3'd5, 16'h0000);
    pulse(1'b1, 1'b0, 1'b0);
    run(1, 32'h0001_0000);
    check("R6 programmed Db", phase, exp_phase(m_acc, 8'h00));

    // R9 soft reset clears state and config
    wr(3'd2, 16'h0080);
    sreset();
    check("R9 cleared phase", phase, 10'd0);
    pulse(1'b1, 1'b0, 1'b0);
    run(1, W_NTSC);
    check("R9 config restored", phase, exp_phase(m_acc, 8'h00));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule